// File: doc/BRIEF.md
# Strided Banked Vector Memory Unit

This unit carries out one vector load or store at a time against a memory split into sixteen word-interleaved banks. A single-cycle start pulse captures a base word address, a stride, an element count and a direction flag. The unit then walks the elements, forming each address by adding the stride to the previous one, and offers at most one request per cycle to the bank named by the low four address bits.

A bank that has just taken a request stays busy for four cycles. An element whose bank is still busy waits, and every element behind it waits too. For a store, the unit names the element it wants on a register read-index output and writes the word that comes back into the bank when the request is taken. For a load, the bank word is read when the request is taken and travels down a fixed twelve-stage pipe together with its element index. It then leaves the unit on a register write port, so results come out in element order.

A one-cycle done pulse closes each operation. A start pulse that arrives while an operation is in progress is ignored.

Top module: `vmu_top`

## Requirements
- R1: After reset, `busy`, `wr_en` and `done` are all 0.
- R2: Element i uses the word address (base + i*stride) mod 2^ADDR_W, wrapping at the top of the address space. Its bank is address bits [3:0] and its row within the bank is the address bits above those.
- R3: A bank takes at most one request in any 4 consecutive cycles, and at most one request is issued per cycle. With free banks, stride 1 issues one element per cycle. Strides 0 and 16 send every element to one bank, so requests are 4 cycles apart. Stride 8 alternates between two banks and issues in pairs.
- R4: A load element's data appears on `wr_en`/`wr_data` exactly 12 cycles after its request is taken.
- R5: The element count is `vlen` clamped to 64. A `vlen` of 0 issues nothing and raises `done` in the cycle after the start is taken.
- R6: Load results are written once each, in rising element order. Each result carries its element number on `wr_idx` and the word last stored at that element's address on `wr_data`.
- R7: For a store, `st_idx` shows the number of the element being offered. The `st_data` value present in the cycle the request is taken is written to that element's address.
- R8: `done` is a single-cycle pulse. For a store it comes one cycle after the last request is taken. For a load it comes one cycle after the last result is written. `busy` is 0 in the cycle `done` is 1.
- R9: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its timing, and no extra requests or writes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| is_store | input | 1 | 1 = store, 0 = load; sampled with start |
| base | input | ADDR_W | First element word address |
| stride | input | ADDR_W | Word distance between elements (mod 2^ADDR_W) |
| vlen | input | IDX_W | Requested element count |
| st_data | input | DATA_W | Store word for element `st_idx` |
| st_idx | output | IDX_W | Element whose store word is wanted |
| busy | output | 1 | An operation is in progress |
| wr_en | output | 1 | Load result valid |
| wr_idx | output | IDX_W | Element number of the load result |
| wr_data | output | DATA_W | Load result word |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
During a load, the issue of a later element and the write-back of an earlier one can happen in the same cycle. This occurs whenever the element count is larger than the twelve-cycle return delay, and with single-bank strides the issue may be stalled in that cycle. The bench provokes this with a 64-element unit-stride load and a 16-stride load, so that stalls, issues and returns interleave. A scoreboard built from a model of the bank contents checks each write-back's index and word in arrival order. The elapsed cycle count to `done` and to the first write-back is compared against counts derived from the bank spacing and the return delay.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
    localparam int VMU_ADDR_W = 8;
    localparam int VMU_DATA_W = 64;
    localparam int VMU_NBANK  = 16;
    localparam int VMU_MAXVL  = 64;
    localparam int VMU_BUSY   = 4;
    localparam int VMU_LAT    = 12;

    typedef enum logic [1:0] {
        VMU_IDLE,
        VMU_RUN,
        VMU_DRAIN
    } vmu_state_e;
endpackage

// File: rtl/vmu_agen.sv
module vmu_agen
    import vmu_pkg::*;
#(
    parameter int ADDR_W = VMU_ADDR_W,
    parameter int IDX_W  = 7,
    parameter int MAXVL  = VMU_MAXVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [IDX_W-1:0]  vlen,
    input  logic              grant,
    input  logic              ret_last,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  req_idx,
    output logic              req_last,
    output logic              req_store,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        vmu_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic [IDX_W-1:0]  elem;
        logic [IDX_W-1:0]  cnt;
        logic              store;
        logic              done;
    } agen_s;

    agen_s q, d;
    logic [IDX_W-1:0] len_clamped;

    always_comb begin
        len_clamped = (vlen > IDX_W'(MAXVL)) ? IDX_W'(MAXVL) : vlen;
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            VMU_IDLE: begin
                if (start) begin
                    if (len_clamped == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st     = VMU_RUN;
                        d.addr   = base;
                        d.stride = stride;
                        d.elem   = '0;
                        d.cnt    = len_clamped;
                        d.store  = is_store;
                    end
                end
            end
            VMU_RUN: begin
                if (grant) begin
                    d.elem = q.elem + 1'b1;
                    d.addr = q.addr + q.stride;
                    if (q.elem == q.cnt - 1'b1) begin
                        if (q.store) begin
                            d.st   = VMU_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st = VMU_DRAIN;
                        end
                    end
                end
            end
            VMU_DRAIN: begin
                if (ret_last) begin
                    d.st   = VMU_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = VMU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: VMU_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_valid = (q.st == VMU_RUN);
    assign req_addr  = q.addr;
    assign req_idx   = q.elem;
    assign req_last  = (q.elem == q.cnt - 1'b1);
    assign req_store = q.store;
    assign busy      = (q.st != VMU_IDLE);
    assign done      = q.done;
endmodule

// File: rtl/vmu_banks.sv
module vmu_banks
    import vmu_pkg::*;
#(
    parameter int ADDR_W = VMU_ADDR_W,
    parameter int DATA_W = VMU_DATA_W,
    parameter int NBANK  = VMU_NBANK,
    parameter int BUSY   = VMU_BUSY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_store,
    input  logic [DATA_W-1:0] wdata,
    output logic              grant,
    output logic [DATA_W-1:0] rdata
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int DEPTH  = 2 ** ROW_W;
    localparam int CNT_W  = $clog2(BUSY + 1);

    typedef struct packed {
        logic [NBANK-1:0][CNT_W-1:0] tmr;
    } bank_s;

    bank_s q, d;
    logic [BANK_W-1:0] bank_sel;
    logic [ROW_W-1:0]  row_sel;
    logic [DATA_W-1:0] rd_bank [NBANK];

    assign bank_sel = req_addr[BANK_W-1:0];
    assign row_sel  = req_addr[ADDR_W-1:BANK_W];
    assign grant    = req_valid && (q.tmr[bank_sel] == '0);

    always_comb begin
        d = q;
        for (int b = 0; b < NBANK; b++) begin
            if (q.tmr[b] != '0) begin
                d.tmr[b] = q.tmr[b] - 1'b1;
            end
            if (grant && (bank_sel == BANK_W'(b))) begin
                d.tmr[b] = CNT_W'(BUSY - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (grant && req_store && (bank_sel == BANK_W'(b))) begin
                mem[row_sel] <= wdata;
            end
        end
        assign rd_bank[b] = mem[row_sel];
    end

    assign rdata = rd_bank[bank_sel];
endmodule

// File: rtl/vmu_retpipe.sv
module vmu_retpipe
    import vmu_pkg::*;
#(
    parameter int LAT    = VMU_LAT,
    parameter int IDX_W  = 7,
    parameter int DATA_W = VMU_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              v;
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } slot_s;

    slot_s [LAT-1:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d[0] = '{v: in_valid, last: in_last, idx: in_idx, data: in_data};
        for (int k = 1; k < LAT; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q[LAT-1].v;
    assign out_last  = pipe_q[LAT-1].last;
    assign out_idx   = pipe_q[LAT-1].idx;
    assign out_data  = pipe_q[LAT-1].data;
endmodule

// File: rtl/vmu_top.sv
module vmu_top
    import vmu_pkg::*;
#(
    parameter int ADDR_W = VMU_ADDR_W,
    parameter int DATA_W = VMU_DATA_W,
    parameter int NBANK  = VMU_NBANK,
    parameter int MAXVL  = VMU_MAXVL,
    parameter int BUSY   = VMU_BUSY,
    parameter int LAT    = VMU_LAT,
    parameter int IDX_W  = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [IDX_W-1:0]  vlen,
    input  logic [DATA_W-1:0] st_data,
    output logic [IDX_W-1:0]  st_idx,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic              req_valid, req_last, req_store, grant, ret_last, out_last;
    logic [ADDR_W-1:0] req_addr;
    logic [IDX_W-1:0]  req_idx;
    logic [DATA_W-1:0] rdata;

    vmu_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAXVL(MAXVL)) u_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .grant(grant),
        .ret_last(ret_last), .req_valid(req_valid), .req_addr(req_addr),
        .req_idx(req_idx), .req_last(req_last), .req_store(req_store),
        .busy(busy), .done(done)
    );

    vmu_banks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .BUSY(BUSY)) u_banks (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_store(req_store), .wdata(st_data), .grant(grant), .rdata(rdata)
    );

    vmu_retpipe #(.LAT(LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .in_valid(grant && !req_store),
        .in_last(req_last), .in_idx(req_idx), .in_data(rdata),
        .out_valid(wr_en), .out_last(out_last), .out_idx(wr_idx),
        .out_data(wr_data)
    );

    assign ret_last = wr_en && out_last;
    assign st_idx   = req_idx;
endmodule

// File: rtl/vmu_chk.sv
module vmu_chk #(
    parameter int ADDR_W = 8,
    parameter int NBANK  = 16,
    parameter int BUSY   = 4,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              grant,
    input logic [ADDR_W-1:0] req_addr
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int AGE_W  = $clog2(BUSY + 1);

    logic [NBANK-1:0][AGE_W-1:0] age_q;
    logic [IDX_W-1:0]            exp_idx_q;
    logic [BANK_W-1:0]           bank;

    assign bank = req_addr[BANK_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) age_q[b] <= AGE_W'(BUSY);
            exp_idx_q <= '0;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (grant && bank == BANK_W'(b)) age_q[b] <= AGE_W'(1);
                else if (age_q[b] < AGE_W'(BUSY)) age_q[b] <= age_q[b] + 1'b1;
            end
            if (start && !busy) exp_idx_q <= '0;
            else if (wr_en) exp_idx_q <= exp_idx_q + 1'b1;
        end
    end

    // R3: bank spacing
    p_bank_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> age_q[bank] >= AGE_W'(BUSY));

    // R6: results in element order
    p_wr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx == exp_idx_q);

    // R8: done is a single pulse while idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: nothing moves while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en && !grant);
endmodule

bind vmu_top vmu_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BUSY(BUSY), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .grant(grant), .req_addr(req_addr)
);

// File: tb/sim_vmu_top.sv
module sim_vmu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_store = 1'b0;
    logic [7:0]  base = '0;
    logic [7:0]  stride = '0;
    logic [6:0]  vlen = '0;
    logic [63:0] st_data;
    logic [6:0]  st_idx;
    logic        busy, wr_en, done;
    logic [6:0]  wr_idx;
    logic [63:0] wr_data;
    logic [7:0]  cur_tag = '0;

    int n_chk = 0;
    int n_bad = 0;
    int wr_seen = 0;
    logic [63:0] model [256];

    typedef struct {
        logic [6:0]  idx;
        logic [63:0] data;
    } exp_t;
    exp_t sb [$];

    always #10 clk = ~clk;

    function automatic logic [63:0] sdat(input logic [7:0] tag, input logic [6:0] idx);
        return {tag, 49'h0, idx};
    endfunction

    assign st_data = sdat(cur_tag, st_idx);

    vmu_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .st_data(st_data),
        .st_idx(st_idx), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard compare of write-backs (R6, R4)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            wr_seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R6/R9", "unexpected write idx", longint'(wr_idx), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(wr_idx == e.idx, "R6", "write idx", longint'(wr_idx), longint'(e.idx));
                check(wr_data == e.data, "R6", "write data", longint'(wr_data), longint'(e.data));
            end
        end
    end

    // run one operation and measure cycles from start-capture edge to done
    task automatic run_op(input bit st, input logic [7:0] b, input logic [7:0] s,
                          input logic [6:0] vl, input logic [7:0] tag,
                          input int exp_lat, input int exp_first, input string req,
                          input bit poke_start);
        int n, lat, first, w0;
        n = (vl > 7'd64) ? 64 : int'(vl);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = b + 8'(i) * s;
            if (st) model[a] = sdat(tag, 7'(i));
            else sb.push_back('{idx: 7'(i), data: model[a]});
        end
        w0 = wr_seen;
        @(negedge clk);
        is_store = st; base = b; stride = s; vlen = vl; cur_tag = tag;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0;
        first = -1;
        forever begin
            @(negedge clk);
            if (wr_en && first < 0) first = lat;
            if (done) break;
            lat++;
            if (poke_start && lat == 5) begin
                start = 1'b1; is_store = 1'b0; base = 8'h11; vlen = 7'd5;
            end else if (poke_start && lat == 6) begin
                start = 1'b0;
            end
            if (lat > 1000) begin
                check(1'b0, req, "watchdog on done", lat, exp_lat);
                break;
            end
        end
        check(lat == exp_lat, req, "cycles to done", lat, exp_lat);
        if (!st) check(first == exp_first, "R4", "cycles to first write", first, exp_first);
        check(wr_seen - w0 == (st ? 0 : n), req, "write count", wr_seen - w0, st ? 0 : n);
        check(sb.size() == 0, req, "scoreboard left", sb.size(), 0);
        @(negedge clk);
        check(!done && !busy, "R8", "done width / busy after", {done, busy}, 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !wr_en && !done, "R1", "reset outputs", {busy, wr_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_en && !done, "R1", "idle after reset", {busy, wr_en, done}, 0);

        // R3 R7: unit stride store, one per cycle
        run_op(1'b1, 8'h00, 8'd1, 7'd64, 8'h01, 64, -1, "R3_R7", 1'b0);
        // R4 R6: unit stride load
        run_op(1'b0, 8'h00, 8'd1, 7'd16, 8'h00, 28, 12, "R4_R6", 1'b0);
        // R3 R9: stride 16 single bank store, stray start mid-run
        run_op(1'b1, 8'h40, 8'd16, 7'd8, 8'h02, 29, -1, "R3_R9", 1'b1);
        // R3 R6: stride 16 load, issue stalls overlapping returns
        run_op(1'b0, 8'h40, 8'd16, 7'd8, 8'h00, 41, 12, "R3_R6", 1'b0);
        // R3: stride 8 pairs
        run_op(1'b1, 8'h03, 8'd8, 7'd4, 8'h03, 6, -1, "R3", 1'b0);
        run_op(1'b0, 8'h03, 8'd8, 7'd4, 8'h00, 18, 12, "R3", 1'b0);
        // R5: clamp to 64
        run_op(1'b1, 8'h80, 8'd1, 7'd100, 8'h04, 64, -1, "R5", 1'b0);
        run_op(1'b0, 8'h80, 8'd1, 7'd100, 8'h00, 76, 12, "R5", 1'b0);
        // R5 R8: zero length
        run_op(1'b0, 8'h20, 8'd1, 7'd0, 8'h00, 0, -1, "R5_R8", 1'b0);
        // R2: address wrap, all banks distinct
        run_op(1'b1, 8'hF8, 8'd3, 7'd10, 8'h05, 10, -1, "R2", 1'b0);
        run_op(1'b0, 8'hF8, 8'd3, 7'd10, 8'h00, 22, 12, "R2", 1'b0);
        // R3: stride 0 load, same bank repeated
        run_op(1'b0, 8'h05, 8'd0, 7'd3, 8'h00, 21, 12, "R3", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule